// File: doc/BRIEF.md
# Interval Timer Channel with Toggle Output

This block is one down-counting timer channel. It issues a periodic interrupt pulse and drives a square wave by flipping an output level each time its counter runs out. Software programs a period register, picks whether the channel should also fire an interrupt at start-up, sets a default output level, and then starts the channel with a one-cycle trigger. Counting is paced by a count-clock enable from a prescaler outside the block.

On the first count tick after start the counter takes the period value. After that it steps down by one on each tick. When it sits at zero, the next tick reloads the period, fires the interrupt and flips the output. A stop trigger freezes the counter and the output level where they are. The current count can be read at any time. The square-wave level reaches the wave output only while the output-enable bit is set.

Top module: `interval_timer_ch`

## Requirements
- R1: After reset, the count reads 0, the run status is 0, the output level is 0, the interrupt is low, and the period register holds 0.
- R2: A start trigger without a stop trigger sets the run status to 1 on the next cycle. The trigger is a one-cycle strobe and is not stored.
- R3: The first count tick after a start loads the period register into the counter. No decrement happens on that tick.
- R4: When the start-interrupt mode input is 1, the load at start also fires the interrupt and flips the output level. When it is 0, neither happens at start.
- R5: While running, each count tick that is not a load lowers the count by one. Without a tick, or while stopped, the count does not change.
- R6: A count tick that finds the count at 0 reloads the period, fires the interrupt and flips the output level. Counting then continues.
- R7: A new period written while running leaves the current count alone and is used at the next reload.
- R8: A stop trigger clears the run status. The counter and output level keep their values. A stop wins over a start and over a count tick in the same cycle.
- R9: A level write sets the output level directly and takes priority over a toggle in the same cycle. The wave output equals the level when output-enable is 1 and is 0 otherwise.
- R10: The interrupt is high for exactly the cycle after each load or reload event and low in any cycle that follows a cycle without a count tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_tick | input | 1 | Count-clock enable from the prescaler |
| period_we | input | 1 | Write strobe for the period register |
| period_wdata | input | CNT_W | New period value |
| start_trig | input | 1 | One-cycle start trigger |
| stop_trig | input | 1 | One-cycle stop trigger |
| irq_at_start | input | 1 | Mode: interrupt and toggle on the first load |
| lvl_we | input | 1 | Write strobe for the output level |
| lvl_wdata | input | 1 | Value to write to the output level |
| oe_we | input | 1 | Write strobe for output-enable |
| oe_wdata | input | 1 | Value to write to output-enable |
| count_q | output | CNT_W | Current counter value |
| run_q | output | 1 | Channel run status |
| irq_o | output | 1 | Interrupt pulse |
| lvl_q | output | 1 | Output level register |
| oe_q | output | 1 | Output-enable status |
| wave_o | output | 1 | Square-wave output, gated by output-enable |

## Verification
Every result is registered once. A trigger, tick or write presented before a rising edge is therefore visible on the outputs during the cycle after that edge. The run status, the count, the interrupt and the level all have this one-cycle latency. A load only happens on the first tick that arrives one edge or more after the start. The bench drives inputs on the falling edge, lets one rising edge pass, and samples on the next falling edge. This keeps every expected value aligned to the single register stage. The step table holds the expected state after each edge, including the frozen count after a stop and a start that lands in the same cycle as a stop.

// File: rtl/itc_pkg.sv
package itc_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_LOAD = 2'd1,
    ACT_DEC  = 2'd2
  } cnt_act_e;
endpackage

// File: rtl/itc_ctl.sv
module itc_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_trig,
  input  logic stop_trig,
  input  logic cnt_tick,
  output logic run_q,
  output logic first_q,
  output logic step
);
  logic run_d, first_d;

  // a tick counts only while running and not being stopped this cycle
  assign step = run_q & cnt_tick & ~stop_trig;

  always_comb begin
    run_d   = run_q;
    first_d = first_q;
    if (stop_trig) begin
      run_d   = 1'b0;
      first_d = 1'b0;
    end else if (start_trig) begin
      run_d   = 1'b1;
      first_d = 1'b1;
    end else if (step) begin
      first_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      first_q <= 1'b0;
    end else begin
      run_q   <= run_d;
      first_q <= first_d;
    end
  end
endmodule

// File: rtl/itc_counter.sv
module itc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             first_q,
  input  logic             irq_at_start,
  input  logic             period_we,
  input  logic [CNT_W-1:0] period_wdata,
  output logic [CNT_W-1:0] count_q,
  output logic             fire,
  output logic             irq_q
);
  import itc_pkg::*;

  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] period_q, period_d, count_d;
  logic             at_zero;
  cnt_act_e         act;

  assign at_zero = (count_q == ZERO);

  always_comb begin
    act  = ACT_HOLD;
    fire = 1'b0;
    if (step) begin
      if (first_q) begin
        act  = ACT_LOAD;
        fire = irq_at_start;
      end else if (at_zero) begin
        act  = ACT_LOAD;
        fire = 1'b1;
      end else begin
        act  = ACT_DEC;
      end
    end
  end

  always_comb begin
    case (act)
      ACT_LOAD: count_d = period_q;
      ACT_DEC:  count_d = count_q - ONE;
      default:  count_d = count_q;
    endcase
    period_d = period_we ? period_wdata : period_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= ZERO;
      period_q <= ZERO;
      irq_q    <= 1'b0;
    end else begin
      count_q  <= count_d;
      period_q <= period_d;
      irq_q    <= fire;
    end
  end
endmodule

// File: rtl/itc_out.sv
module itc_out (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic lvl_we,
  input  logic lvl_wdata,
  input  logic oe_we,
  input  logic oe_wdata,
  output logic lvl_q,
  output logic oe_q,
  output logic wave_o
);
  logic lvl_d, oe_d;

  always_comb begin
    lvl_d = lvl_q;
    if (lvl_we)    lvl_d = lvl_wdata;
    else if (fire) lvl_d = ~lvl_q;
    oe_d = oe_we ? oe_wdata : oe_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
      oe_q  <= oe_d;
    end
  end

  assign wave_o = oe_q & lvl_q;
endmodule

// File: rtl/interval_timer_ch.sv
module interval_timer_ch #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_tick,
  input  logic             period_we,
  input  logic [CNT_W-1:0] period_wdata,
  input  logic             start_trig,
  input  logic             stop_trig,
  input  logic             irq_at_start,
  input  logic             lvl_we,
  input  logic             lvl_wdata,
  input  logic             oe_we,
  input  logic             oe_wdata,
  output logic [CNT_W-1:0] count_q,
  output logic             run_q,
  output logic             irq_o,
  output logic             lvl_q,
  output logic             oe_q,
  output logic             wave_o
);
  logic first_q, step, fire;

  itc_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .start_trig(start_trig), .stop_trig(stop_trig),
    .cnt_tick(cnt_tick), .run_q(run_q), .first_q(first_q), .step(step)
  );

  itc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .first_q(first_q),
    .irq_at_start(irq_at_start), .period_we(period_we),
    .period_wdata(period_wdata), .count_q(count_q), .fire(fire), .irq_q(irq_o)
  );

  itc_out u_out (
    .clk(clk), .rst_n(rst_n), .fire(fire), .lvl_we(lvl_we),
    .lvl_wdata(lvl_wdata), .oe_we(oe_we), .oe_wdata(oe_wdata),
    .lvl_q(lvl_q), .oe_q(oe_q), .wave_o(wave_o)
  );
endmodule

// File: rtl/itc_checker.sv
module itc_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_tick,
  input logic             start_trig,
  input logic             stop_trig,
  input logic             lvl_we,
  input logic             first_q,
  input logic             run_q,
  input logic [CNT_W-1:0] count_q,
  input logic             irq_o,
  input logic             lvl_q
);
  p_stop_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_trig |=> !run_q);

  p_start_runs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_trig && !stop_trig) |=> run_q);

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> $stable(count_q));

  p_step_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_tick && !stop_trig && !first_q && count_q != '0)
      |=> (CNT_W'(count_q + 1'b1) == $past(count_q)));

  p_no_tick_no_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_tick |=> !irq_o);

  p_lvl_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl_we |=> (irq_o || lvl_q == $past(lvl_q)));
endmodule

bind interval_timer_ch itc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .start_trig(start_trig),
  .stop_trig(stop_trig), .lvl_we(lvl_we), .first_q(first_q), .run_q(run_q),
  .count_q(count_q), .irq_o(irq_o), .lvl_q(lvl_q)
);

// File: tb/tb_interval_timer_ch.sv
module tb_interval_timer_ch;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cnt_tick = 1'b0, period_we = 1'b0, start_trig = 1'b0, stop_trig = 1'b0;
  logic         irq_at_start = 1'b0, lvl_we = 1'b0, lvl_wdata = 1'b0, oe_we = 1'b0, oe_wdata = 1'b0;
  logic [W-1:0] period_wdata = '0;
  logic [W-1:0] count_q;
  logic         run_q, irq_o, lvl_q, oe_q, wave_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  interval_timer_ch #(.CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .period_we(period_we),
    .period_wdata(period_wdata), .start_trig(start_trig), .stop_trig(stop_trig),
    .irq_at_start(irq_at_start), .lvl_we(lvl_we), .lvl_wdata(lvl_wdata),
    .oe_we(oe_we), .oe_wdata(oe_wdata), .count_q(count_q), .run_q(run_q),
    .irq_o(irq_o), .lvl_q(lvl_q), .oe_q(oe_q), .wave_o(wave_o)
  );

  // {tick, start, stop, exp_run, exp_count[15:0], exp_irq, exp_lvl}
  // period 3, start-interrupt mode on, output enabled, level 0, count 0
  localparam int NV = 13;
  localparam logic [21:0] VEC [NV] = '{
    {1'b0, 1'b1, 1'b0, 1'b1, 16'd0, 1'b0, 1'b0},  // start
    {1'b1, 1'b0, 1'b0, 1'b1, 16'd3, 1'b1, 1'b1},  // first load
    {1'b0, 1'b0, 1'b0, 1'b1, 16'd3, 1'b0, 1'b1},  // no tick
    {1'b1, 1'b0, 1'b0, 1'b1, 16'd2, 1'b0, 1'b1},
    {1'b1, 1'b0, 1'b0, 1'b1, 16'd1, 1'b0, 1'b1},
    {1'b1, 1'b0, 1'b0, 1'b1, 16'd0, 1'b0, 1'b1},
    {1'b1, 1'b0, 1'b0, 1'b1, 16'd3, 1'b1, 1'b0},  // reload at zero
    {1'b1, 1'b0, 1'b0, 1'b1, 16'd2, 1'b0, 1'b0},
    {1'b1, 1'b0, 1'b1, 1'b0, 16'd2, 1'b0, 1'b0},  // stop beats tick
    {1'b1, 1'b0, 1'b0, 1'b0, 16'd2, 1'b0, 1'b0},  // held
    {1'b0, 1'b1, 1'b1, 1'b0, 16'd2, 1'b0, 1'b0},  // stop beats start
    {1'b1, 1'b1, 1'b0, 1'b1, 16'd2, 1'b0, 1'b0},  // start, tick not yet used
    {1'b1, 1'b0, 1'b0, 1'b1, 16'd3, 1'b1, 1'b1}   // load after restart
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    start_trig = 1'b0; stop_trig = 1'b0; period_we = 1'b0;
    lvl_we = 1'b0; oe_we = 1'b0; cnt_tick = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic lvl_save;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 count", 32'(count_q), 0);
    chk("R1 run", 32'(run_q), 0);
    chk("R1 lvl", 32'(lvl_q), 0);
    chk("R1 irq", 32'(irq_o), 0);
    // R1 period cleared: load gives 0; mode 0 so no irq (R4)
    start_trig = 1'b1; cyc();
    cnt_tick = 1'b1; cyc();
    chk("R1 period zero load", 32'(count_q), 0);
    chk("R4 mode0 no irq", 32'(irq_o), 0);
    cnt_tick = 1'b1; cyc();
    chk("R6 reload at zero irq", 32'(irq_o), 1);
    chk("R6 toggle", 32'(lvl_q), 1);
    stop_trig = 1'b1; cyc();

    // table setup
    period_we = 1'b1; period_wdata = 16'd3; irq_at_start = 1'b1;
    oe_we = 1'b1; oe_wdata = 1'b1; lvl_we = 1'b1; lvl_wdata = 1'b0;
    cyc();
    for (int i = 0; i < NV; i++) begin
      cnt_tick = VEC[i][21]; start_trig = VEC[i][20]; stop_trig = VEC[i][19];
      cyc();
      chk($sformatf("R2/R8 run step %0d", i), 32'(run_q), 32'(VEC[i][18]));
      chk($sformatf("R3/R5 count step %0d", i), 32'(count_q), 32'(VEC[i][17:2]));
      chk($sformatf("R4/R6 irq step %0d", i), 32'(irq_o), 32'(VEC[i][1]));
      chk($sformatf("R6 lvl step %0d", i), 32'(lvl_q), 32'(VEC[i][0]));
      chk($sformatf("R9 wave step %0d", i), 32'(wave_o), 32'(VEC[i][0]));
    end

    // R10: irq drops after a cycle without tick
    cyc();
    chk("R10 irq one cycle", 32'(irq_o), 0);
    // R7: period change while running, count 3
    period_we = 1'b1; period_wdata = 16'd5; cnt_tick = 1'b1; cyc();
    chk("R7 count untouched", 32'(count_q), 2);
    cnt_tick = 1'b1; cyc();
    cnt_tick = 1'b1; cyc();
    chk("R5 reaches zero", 32'(count_q), 0);
    cnt_tick = 1'b1; cyc();
    chk("R7 new period at reload", 32'(count_q), 5);
    chk("R10 irq on reload", 32'(irq_o), 1);
    // R4: mode 0, no irq or toggle at start
    stop_trig = 1'b1; cyc();
    irq_at_start = 1'b0; period_we = 1'b1; period_wdata = 16'd2; start_trig = 1'b1; cyc();
    lvl_save = lvl_q;
    cnt_tick = 1'b1; cyc();
    chk("R4 mode0 load", 32'(count_q), 2);
    chk("R4 mode0 irq", 32'(irq_o), 0);
    chk("R4 mode0 lvl", 32'(lvl_q), 32'(lvl_save));
    // R9: level write beats toggle, output-enable gating
    cnt_tick = 1'b1; cyc();
    cnt_tick = 1'b1; cyc();
    chk("R5 down to zero", 32'(count_q), 0);
    lvl_save = lvl_q;
    cnt_tick = 1'b1; lvl_we = 1'b1; lvl_wdata = lvl_save; cyc();
    chk("R9 write beats toggle", 32'(lvl_q), 32'(lvl_save));
    chk("R6 irq still fires", 32'(irq_o), 1);
    stop_trig = 1'b1; oe_we = 1'b1; oe_wdata = 1'b0; lvl_we = 1'b1; lvl_wdata = 1'b1; cyc();
    chk("R9 lvl written", 32'(lvl_q), 1);
    chk("R9 wave gated", 32'(wave_o), 0);
    chk("R8 count held", 32'(count_q), 2);
    oe_we = 1'b1; oe_wdata = 1'b1; cyc();
    chk("R9 wave enabled", 32'(wave_o), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule